// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned operands and a carry-in. The full sum comes out on a `WIDTH`-bit result and a carry-out. All carries are formed at once by a radix-2 parallel-prefix tree with no sparse levels. At tree level j, each lane merges its running group with the group 2^j lanes below it. The tree has ceil(log2(WIDTH+1)) levels. The carry-in takes part as an extra lane below bit 0. It acts only as a generate, so every prefix that reaches down to it already includes the incoming carry.

Each bit works out its sum for both possible incoming carries while the tree runs. A final stage of 2:1 multiplexers picks between the two, using that bit's carry from the tree. In the default setting the sum and carry-out are registered, so a result appears one clock after its operands are sampled. A new operand pair can be given on every cycle. A parameter can switch the tree's propagate term from XOR to OR. The arithmetic result is the same either way.

Top module: `ks_prefix_adder`

## Requirements
- R1: While `rst` is high at a rising edge, `sum` and `cout` read 0 after that edge, whatever the operands are.
- R2: With OUT_REG=1, `sum` equals the low WIDTH bits of a + b + cin, using the operands sampled at the previous rising edge.
- R3: `cout` equals bit WIDTH (the bit just above the MSB) of the same a + b + cin total.
- R4: When every bit position propagates ((a XOR b) all ones) and cin=1, the carry-in ripples through the whole word: sum=0 and cout=1.
- R5: A carry generated at any bit k (a[k]=b[k]=1) passes through a run of propagating bits up to the MSB. For a = ones from bit k to the MSB, b = 1<<k and cin=0, the result is sum=0 and cout=1, for every k.
- R6: A generate at the MSB alone (a = b = 1<<(WIDTH-1), cin=0) gives sum=0 and cout=1.
- R7: With no generates and no propagates (a=b=0), the only effect is the carry-in: sum = cin and cout = 0.
- R8: Operand pairs given on consecutive cycles each produce their own correct result exactly one cycle later. No carry leaks from one operation into the next.
- R9: The same results hold at WIDTH=64 with the OR form of propagate in the tree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the MSB |

## Verification
The bench targets the longest carry paths. It sends the carry-in through a word that propagates everywhere, and it starts a generate at each bit position in turn below a run of propagates. A tree that skipped a level, or got the lane spacing wrong at some level, would leave some of those sums nonzero and drop the carry-out. Lone MSB generates and all-kill words check that a carry is neither lost at the top nor made from nothing. A sum-select that picked the wrong precomputed half would invert result bits. Back-to-back operands and a reset in mid-stream expose results that are stale or leak over from the last operation. The same tests at 64 bits with OR propagate show whether the deepest level is missing.

// File: rtl/ks_adder_pkg.sv
package ks_adder_pkg;

  // Group generate of (hi over lo): hi generates, or hi passes what lo generates.
  function automatic logic grp_gen(input logic hi_g, input logic hi_p, input logic lo_g);
    return hi_g | (hi_p & lo_g);
  endfunction

  // Group propagate: both halves must pass a carry through.
  function automatic logic grp_prop(input logic hi_p, input logic lo_p);
    return hi_p & lo_p;
  endfunction

endpackage

// File: rtl/ks_bit_cells.sv
module ks_bit_cells #(
  parameter int WIDTH       = 16,
  parameter bit USE_OR_PROP = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH:0]   leaf_g,
  output logic [WIDTH:1]   leaf_p,
  output logic [WIDTH-1:0] sum_if0,
  output logic [WIDTH-1:0] sum_if1
);

  logic [WIDTH-1:0] half;

  assign half = a ^ b;

  // Lane 0 is the carry-in acting as a pure generate; lane i+1 is bit i.
  assign leaf_g = {a & b, cin};

  if (USE_OR_PROP) begin : g_prop_or
    assign leaf_p = a | b;
  end else begin : g_prop_xor
    assign leaf_p = half;
  end

  // Sums for both possible incoming carries, formed beside the tree.
  assign sum_if0 = half;
  assign sum_if1 = ~half;

endmodule

// File: rtl/ks_prefix_tree.sv
module ks_prefix_tree #(
  parameter int NP = 17
) (
  input  logic [NP-1:0] leaf_g,
  input  logic [NP-1:1] leaf_p,
  output logic [NP-1:0] carry
);

  localparam int LEVELS = $clog2(NP);

  for (genvar j = 0; j < LEVELS; j++) begin : g_lvl
    localparam int D = 1 << j;

    logic [NP-1:0] sg;
    logic [NP-1:D] sp;
    logic [NP-1:0] gv;

    if (j == 0) begin : g_src_leaf
      assign sg = leaf_g;
      assign sp = leaf_p[NP-1:D];
    end else begin : g_src_prev
      assign sg = g_lvl[j-1].gv;
      assign sp = g_lvl[j-1].g_pout.pv;
    end

    // Lanes below D already span down to the carry-in lane: pass through.
    for (genvar i = 0; i < NP; i++) begin : g_cell
      if (i < D) begin : g_pass
        assign gv[i] = sg[i];
      end else begin : g_merge
        assign gv[i] = ks_adder_pkg::grp_gen(sg[i], sp[i], sg[i-D]);
      end
    end

    // Group propagate is kept only for lanes whose span has not yet reached
    // lane 0; lanes that have reached it need only the generate.
    if (2 * D <= NP - 1) begin : g_pout
      logic [NP-1:2*D] pv;
      for (genvar i = 2 * D; i < NP; i++) begin : g_black
        assign pv[i] = ks_adder_pkg::grp_prop(sp[i], sp[i-D]);
      end
    end
  end

  assign carry = g_lvl[LEVELS-1].gv;

endmodule

// File: rtl/ks_sum_select.sv
module ks_sum_select #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH:0]   carry,
  input  logic [WIDTH-1:0] sum_if0,
  input  logic [WIDTH-1:0] sum_if1,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pick
    assign sum[i] = carry[i] ? sum_if1[i] : sum_if0[i];
  end

  assign cout = carry[WIDTH];

endmodule

// File: rtl/ks_prefix_adder.sv
module ks_prefix_adder #(
  parameter int WIDTH       = 16,
  parameter bit OUT_REG     = 1'b1,
  parameter bit USE_OR_PROP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NP = WIDTH + 1;

  logic [NP-1:0]    leaf_g;
  logic [NP-1:1]    leaf_p;
  logic [WIDTH-1:0] sum_if0;
  logic [WIDTH-1:0] sum_if1;
  logic [NP-1:0]    carry;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;

  ks_bit_cells #(.WIDTH(WIDTH), .USE_OR_PROP(USE_OR_PROP)) u_cells (
    .a(a), .b(b), .cin(cin),
    .leaf_g(leaf_g), .leaf_p(leaf_p),
    .sum_if0(sum_if0), .sum_if1(sum_if1)
  );

  ks_prefix_tree #(.NP(NP)) u_tree (
    .leaf_g(leaf_g), .leaf_p(leaf_p), .carry(carry)
  );

  ks_sum_select #(.WIDTH(WIDTH)) u_sel (
    .carry(carry), .sum_if0(sum_if0), .sum_if1(sum_if1),
    .sum(sum_c), .cout(cout_c)
  );

  if (OUT_REG) begin : g_out_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_c;
        cout <= cout_c;
      end
    end
  end else begin : g_out_comb
    assign sum  = sum_c;
    assign cout = cout_c;
  end

endmodule

// File: rtl/ks_prefix_adder_chk.sv
module ks_prefix_adder_chk #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  if (OUT_REG) begin : g_seq
    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (sum == '0) && !cout);
    // R2
    p_sum_r2: assert property (@(posedge clk) disable iff (rst)
      !rst |=> sum == $past(ref_total[WIDTH-1:0]));
    // R3
    p_cout_r3: assert property (@(posedge clk) disable iff (rst)
      !rst |=> cout == $past(ref_total[WIDTH]));
    // R4
    p_cin_chain_r4: assert property (@(posedge clk) disable iff (rst)
      ((&(a ^ b)) && cin) |=> (sum == '0) && cout);
    // R6
    p_msb_gen_r6: assert property (@(posedge clk) disable iff (rst)
      (a[WIDTH-1] && b[WIDTH-1]) |=> cout);
  end else begin : g_comb
    p_sum_r2: assert property (@(posedge clk) disable iff (rst)
      !rst |-> sum == ref_total[WIDTH-1:0]);
    p_cout_r3: assert property (@(posedge clk) disable iff (rst)
      !rst |-> cout == ref_total[WIDTH]);
    p_cin_chain_r4: assert property (@(posedge clk) disable iff (rst)
      ((&(a ^ b)) && cin) |-> (sum == '0) && cout);
    p_msb_gen_r6: assert property (@(posedge clk) disable iff (rst)
      (a[WIDTH-1] && b[WIDTH-1]) |-> cout);
  end

endmodule

bind ks_prefix_adder ks_prefix_adder_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/ks_prefix_adder_test.sv
`timescale 1ns/1ps
module ks_prefix_adder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a   = '0;
  logic [63:0] b   = '0;
  logic        cin = 1'b0;
  logic [15:0] s16;
  logic        co16;
  logic [63:0] s64;
  logic        co64;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ks_prefix_adder #(.WIDTH(16)) uut (
    .clk(clk), .rst(rst), .a(a[15:0]), .b(b[15:0]), .cin(cin),
    .sum(s16), .cout(co16)
  );

  // R9: wide instance with the OR propagate variant
  ks_prefix_adder #(.WIDTH(64), .USE_OR_PROP(1'b1)) uut_w64 (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
    .sum(s64), .cout(co64)
  );

  task automatic check(input string req, input string what,
                       input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [63:0] ea,
                              input logic [63:0] eb, input logic ec);
    logic [16:0] e16;
    logic [64:0] e64;
    e16 = {1'b0, ea[15:0]} + {1'b0, eb[15:0]} + {16'd0, ec};
    e64 = {1'b0, ea} + {1'b0, eb} + {64'd0, ec};
    check(req, "w16", {48'd0, co16, s16}, {48'd0, e16});
    check({req, "/R9"}, "w64", {co64, s64}, e64);
  endtask

  task automatic run_one(input string req, input logic [63:0] ea,
                         input logic [63:0] eb, input logic ec);
    @(negedge clk);
    a = ea; b = eb; cin = ec;
    @(negedge clk);
    check_result(req, ea, eb, ec);
  endtask

  task automatic t_reset;
    @(negedge clk);
    a = '1; b = '1; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "w16", {48'd0, co16, s16}, 65'd0);
    check("R1", "w64", {co64, s64}, 65'd0);
    rst = 1'b0;
  endtask

  task automatic t_kill;
    run_one("R7", 64'd0, 64'd0, 1'b0);
    run_one("R7", 64'd0, 64'd0, 1'b1);
  endtask

  task automatic t_cin_chain;
    run_one("R4", '1, 64'd0, 1'b1);
    run_one("R4", 64'h5555_5555_5555_5555, 64'haaaa_aaaa_aaaa_aaaa, 1'b1);
    run_one("R3", '1, 64'd1, 1'b0);
  endtask

  task automatic t_gen_run;
    for (int k = 0; k < 64; k++) begin
      run_one("R5", ~((64'd1 << k) - 64'd1), 64'd1 << k, 1'b0);
    end
  endtask

  task automatic t_msb;
    run_one("R6", 64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 1'b0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++) begin
      run_one("R2/R3", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end
  endtask

  task automatic t_back_to_back;
    logic [63:0] pa, pb;
    logic        pc;
    @(negedge clk);
    pa = {$urandom, $urandom}; pb = {$urandom, $urandom}; pc = 1'($urandom);
    a = pa; b = pb; cin = pc;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      check_result("R8", pa, pb, pc);
      // alternate all-carry and no-carry operands to expose leakage
      if (n % 2 == 0) begin
        pa = '1; pb = '1; pc = 1'b1;
      end else begin
        pa = {$urandom, $urandom} & 64'h0f0f_0f0f_0f0f_0f0f; pb = 64'd0; pc = 1'b0;
      end
      a = pa; b = pb; cin = pc;
    end
    @(negedge clk);
    check_result("R8", pa, pb, pc);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    a = '1; b = 64'd1; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1", "w16", {48'd0, co16, s16}, 65'd0);
    check("R1", "w64", {co64, s64}, 65'd0);
    @(negedge clk);
    check("R1", "w64 held", {co64, s64}, 65'd0);
    rst = 1'b0;
    @(negedge clk);
    check_result("R1", '1, 64'd1, 1'b1);
  endtask

  initial begin
    t_reset;
    t_kill;
    t_cin_chain;
    t_gen_run;
    t_msb;
    t_random;
    t_back_to_back;
    t_reset_mid;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule